// File: doc/BRIEF.md
# Interrupt Mask and Pending-Status Unit

This unit sits beside a small processor core and decides which interrupt request goes to the core. It handles three vectored maskable request lines, called level 7.5, level 6.5 and level 5.5, and one request line that cannot be masked. The core controls it through a single write byte. In the same write, that byte can change the three mask bits, clear the captured edge on level 7.5, and update a serial output pin. The core reads back the state as a single status byte. That byte holds the serial input pin, the three pending bits, the global enable and the masks.

Separate enable and disable commands set and clear a global enable. Level 7.5 is captured on its rising edge and stays pending until something removes it. Levels 6.5 and 5.5 follow their input levels. On every cycle the unit presents the highest-priority request that is allowed through, as a registered valid flag with a two-bit source code. An acknowledge from the core accepts the presented request.

Top module: `irq_mask_unit`

## Requirements
- R1: After a synchronous reset, all three masks are 1, the global enable is 0, the serial output is 0, the level-7.5 capture is clear and no request is presented. The status byte then reads 8'h07 when the serial input is 0.
- R2: A write whose bit 3 (mask-set enable) is 0 leaves all three mask bits unchanged.
- R3: A write whose bit 3 is 1 loads the masks from bits 2..0. Bit 2 belongs to level 7.5, bit 1 to level 6.5 and bit 0 to level 5.5, and a 1 masks the level.
- R4: The serial output pin takes write bit 7 only when write bit 6 is 1. Otherwise the pin keeps its value.
- R5: A rising edge on the level-7.5 input sets its pending bit. The bit stays set after the input falls. It clears on a write with bit 4 set or on an acknowledge of level 7.5. An input held high does not set it again.
- R6: The pending bits of levels 6.5 and 5.5 follow their inputs.
- R7: The status byte is registered and shows the state of the previous cycle. Bit 7 is the serial input, bits 6..4 are pending for 7.5, 6.5 and 5.5, bit 3 is the global enable, and bits 2..0 are the masks.
- R8: The enable command sets the global enable and the disable command clears it. When both come in the same cycle, the disable wins.
- R9: The non-maskable input is presented with source code 0 whatever the masks or the global enable are.
- R10: The priority order is non-maskable, then 7.5 (code 1), then 6.5 (code 2), then 5.5 (code 3). A maskable level is presented only when it is pending, its mask is 0 and the global enable is 1. The presented value is registered one cycle after its cause.
- R11: An acknowledge of a presented maskable request clears the global enable. In the same cycle it takes priority over an enable command. The valid flag drops in the cycle after any acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the control byte |
| wr_data | input | 8 | Control byte |
| ei_cmd | input | 1 | Set the global enable |
| di_cmd | input | 1 | Clear the global enable |
| nmi_req | input | 1 | Non-maskable request, level-sensed |
| lvl_req | input | 3 | Maskable requests; bit 2 is level 7.5, bit 1 is 6.5, bit 0 is 5.5 |
| sid_pin | input | 1 | Serial input pin |
| ack | input | 1 | Acknowledge of the presented request |
| rd_data | output | 8 | Status byte |
| sod_pin | output | 1 | Serial output pin |
| irq_valid | output | 1 | A request is presented |
| irq_id | output | 2 | Source code of the presented request |

## Verification
The assertions check on every cycle that the masks are held or loaded according to the mask-set enable and that the serial output only moves on an enabled write. They also check that a captured 7.5 edge is held until it is cleared, that a disable or an acceptance leaves the enable at 0, that the non-maskable input always wins, and that a maskable source is only presented while the enable was set. Only the bench scenarios can show the exact layout of the status byte and the full priority order across every combination of mask, enable and request. The same holds for the difference between an edge capture and a level that is held high after a clear.

// File: rtl/irq_mask_pkg.sv
package irq_mask_pkg;
  localparam int NUM_MASK  = 3;
  localparam int BYTE_W    = 8;
  localparam int ID_W      = $clog2(NUM_MASK + 1);
  // control byte field positions
  localparam int WB_SOD    = 7;
  localparam int WB_SOE    = 6;
  localparam int WB_CLR_HI = 4;
  localparam int WB_MSE    = 3;
  typedef enum logic [1:0] {
    SRC_NMI = 2'd0,
    SRC_L75 = 2'd1,
    SRC_L65 = 2'd2,
    SRC_L55 = 2'd3
  } irq_src_e;
endpackage

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs #(
  parameter int NUM_MASK = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic                wr_mse,
  input  logic [NUM_MASK-1:0] wr_mask,
  input  logic                wr_soe,
  input  logic                wr_sod,
  input  logic                ei_cmd,
  input  logic                di_cmd,
  input  logic                accept,
  output logic [NUM_MASK-1:0] mask_q,
  output logic                ie_q,
  output logic                sod_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '1;
      ie_q   <= 1'b0;
      sod_q  <= 1'b0;
    end else begin
      if (wr_en && wr_mse) mask_q <= wr_mask;
      if (wr_en && wr_soe) sod_q  <= wr_sod;
      if (accept || di_cmd) ie_q  <= 1'b0;
      else if (ei_cmd)      ie_q  <= 1'b1;
    end
  end

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && wr_mse) |=> $stable(mask_q)); // R2
  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_mse) |=> mask_q == $past(wr_mask)); // R3
  AST_SOD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && wr_soe) |=> $stable(sod_q)); // R4
  AST_DIS_WINS: assert property (@(posedge clk) disable iff (rst)
    di_cmd |=> !ie_q); // R8
endmodule

// File: rtl/irq_edge_latch.sv
module irq_edge_latch (
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic clr,
  output logic pend_q
);
  logic prev_q;
  logic rise;

  assign rise = req && !prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= req;
      if (rise)     pend_q <= 1'b1;
      else if (clr) pend_q <= 1'b0;
    end
  end

  AST_EDGE_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    $rose(req) |=> pend_q); // R5
  AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (pend_q && !clr) |=> pend_q); // R5
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel #(
  parameter int NUM_MASK = 3,
  parameter int ID_W     = 2
) (
  input  logic                nmi,
  input  logic [NUM_MASK-1:0] act,
  output logic                valid,
  output logic [ID_W-1:0]     id
);
  // highest index is highest maskable priority; code = NUM_MASK - index
  always_comb begin
    valid = 1'b0;
    id    = '0;
    for (int i = 0; i < NUM_MASK; i++) begin
      if (act[i]) begin
        valid = 1'b1;
        id    = ID_W'(NUM_MASK - i);
      end
    end
    if (nmi) begin
      valid = 1'b1;
      id    = '0;
    end
  end
endmodule

// File: rtl/irq_mask_unit.sv
module irq_mask_unit
  import irq_mask_pkg::*;
#(
  parameter int NM = NUM_MASK
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              ei_cmd,
  input  logic              di_cmd,
  input  logic              nmi_req,
  input  logic [NM-1:0]     lvl_req,
  input  logic              sid_pin,
  input  logic              ack,
  output logic [BYTE_W-1:0] rd_data,
  output logic              sod_pin,
  output logic              irq_valid,
  output logic [ID_W-1:0]   irq_id
);
  localparam int EDGE_IDX = NM - 1;

  logic [NM-1:0]   mask_q;
  logic [NM-1:0]   pend;
  logic [NM-1:0]   act;
  logic            ie_q;
  logic            accept;
  logic            ack_edge;
  logic            clr_edge;
  logic            sel_valid;
  logic [ID_W-1:0] sel_id;
  logic            unused_wbit;

  assign unused_wbit = wr_data[5];

  assign accept   = ack && irq_valid && (irq_id != SRC_NMI);
  assign ack_edge = ack && irq_valid && (irq_id == SRC_L75);
  assign clr_edge = (wr_en && wr_data[WB_CLR_HI]) || ack_edge;

  irq_ctrl_regs #(.NUM_MASK(NM)) regs_i (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_mse  (wr_data[WB_MSE]),
    .wr_mask (wr_data[NM-1:0]),
    .wr_soe  (wr_data[WB_SOE]),
    .wr_sod  (wr_data[WB_SOD]),
    .ei_cmd  (ei_cmd),
    .di_cmd  (di_cmd),
    .accept  (accept),
    .mask_q  (mask_q),
    .ie_q    (ie_q),
    .sod_q   (sod_pin)
  );

  for (genvar i = 0; i < NM; i++) begin : g_pend
    if (i == EDGE_IDX) begin : g_edge
      irq_edge_latch edge_i (
        .clk    (clk),
        .rst    (rst),
        .req    (lvl_req[i]),
        .clr    (clr_edge),
        .pend_q (pend[i])
      );
    end else begin : g_level
      assign pend[i] = lvl_req[i];
    end
  end

  assign act = pend & ~mask_q & {NM{ie_q}};

  irq_prio_sel #(.NUM_MASK(NM), .ID_W(ID_W)) sel_i (
    .nmi   (nmi_req),
    .act   (act),
    .valid (sel_valid),
    .id    (sel_id)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_valid <= 1'b0;
      irq_id    <= '0;
      rd_data   <= '0;
    end else begin
      irq_valid <= ack ? 1'b0 : sel_valid;
      irq_id    <= sel_id;
      rd_data   <= {sid_pin, pend, ie_q, mask_q};
    end
  end

  AST_NMI_WINS: assert property (@(posedge clk) disable iff (rst)
    (nmi_req && !ack) |=> (irq_valid && irq_id == SRC_NMI)); // R9
  AST_ACCEPT_CLR: assert property (@(posedge clk) disable iff (rst)
    accept |=> !ie_q); // R11
  AST_ACK_DROP: assert property (@(posedge clk) disable iff (rst)
    ack |=> !irq_valid); // R11
  AST_MASKABLE_GATED: assert property (@(posedge clk) disable iff (rst)
    (irq_valid && irq_id != SRC_NMI) |-> $past(ie_q)); // R10
endmodule

// File: tb/irq_mask_unit_tb.sv
`timescale 1ns/1ps
module irq_mask_unit_tb_top;
  logic       clk = 1'b0;
  logic       rst;
  logic       wr_en, ei_cmd, di_cmd, nmi_req, sid_pin, ack;
  logic [7:0] wr_data;
  logic [2:0] lvl_req;
  logic [7:0] rd_data;
  logic       sod_pin, irq_valid;
  logic [1:0] irq_id;
  int         n_chk = 0;
  int         n_fail = 0;
  bit         done = 0;

  always #4 clk = ~clk;

  irq_mask_unit dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .ei_cmd(ei_cmd), .di_cmd(di_cmd), .nmi_req(nmi_req),
    .lvl_req(lvl_req), .sid_pin(sid_pin), .ack(ack),
    .rd_data(rd_data), .sod_pin(sod_pin), .irq_valid(irq_valid),
    .irq_id(irq_id)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic write_byte(input logic [7:0] b);
    @(negedge clk); wr_en = 1'b1; wr_data = b;
    @(negedge clk); wr_en = 1'b0; wr_data = 8'h00;
  endtask

  task automatic pulse_cmd(input logic e, input logic d);
    @(negedge clk); ei_cmd = e; di_cmd = d;
    @(negedge clk); ei_cmd = 1'b0; di_cmd = 1'b0;
  endtask

  initial begin
    rst = 1'b1; wr_en = 0; wr_data = 0; ei_cmd = 0; di_cmd = 0;
    nmi_req = 0; sid_pin = 0; ack = 0; lvl_req = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 status", rd_data, 8'h07);
    chk("R1 valid", {7'b0, irq_valid}, 8'h00);
    chk("R1 sod", {7'b0, sod_pin}, 8'h00);

    // R7 R10 sweep: mask x enable x requests
    for (int c = 0; c < 256; c++) begin
      logic [2:0] m;
      logic       ien, sid, ev;
      logic [3:0] r;
      logic [1:0] eid;
      m = c[2:0]; ien = c[3]; r = c[7:4]; sid = c[0] ^ c[5];
      @(negedge clk);
      nmi_req = 0; lvl_req = 0; wr_en = 1; wr_data = {5'b00011, m};
      ei_cmd = ien; di_cmd = !ien;
      @(negedge clk);
      wr_en = 0; wr_data = 0; ei_cmd = 0; di_cmd = 0;
      nmi_req = r[3]; lvl_req = r[2:0]; sid_pin = sid;
      @(negedge clk); @(negedge clk);
      ev = r[3] || (ien && ((r[2:0] & ~m) != 3'b000));
      if (r[3])                  eid = 2'd0;
      else if (r[2] && !m[2])    eid = 2'd1;
      else if (r[1] && !m[1])    eid = 2'd2;
      else                       eid = 2'd3;
      chk("R7 status byte", rd_data, {sid, r[2:0], ien, m});
      chk("R10 valid", {7'b0, irq_valid}, {7'b0, ev});
      if (ev) chk("R10 id", {6'b0, irq_id}, {6'b0, eid});
    end
    nmi_req = 0; lvl_req = 0; sid_pin = 0;
    write_byte(8'h10); pulse_cmd(1'b0, 1'b1);

    // R2 / R3 masks
    write_byte(8'b0000_1101);
    write_byte(8'b0000_0010);
    @(negedge clk);
    chk("R2 mask kept", {5'b0, rd_data[2:0]}, 8'h05);
    write_byte(8'b0000_1010);
    @(negedge clk);
    chk("R3 mask load", {5'b0, rd_data[2:0]}, 8'h02);

    // R4 serial output
    write_byte(8'b1100_0000);
    chk("R4 sod set", {7'b0, sod_pin}, 8'h01);
    write_byte(8'b0000_0000);
    chk("R4 sod held", {7'b0, sod_pin}, 8'h01);
    write_byte(8'b1000_0000);
    chk("R4 sod held2", {7'b0, sod_pin}, 8'h01);
    write_byte(8'b0100_0000);
    chk("R4 sod clear", {7'b0, sod_pin}, 8'h00);

    // R5 edge capture on level 7.5
    @(negedge clk); lvl_req[2] = 1'b1;
    @(negedge clk); lvl_req[2] = 1'b0;
    repeat (4) @(negedge clk);
    chk("R5 held after drop", {7'b0, rd_data[6]}, 8'h01);
    write_byte(8'h10);
    @(negedge clk);
    chk("R5 cleared by write", {7'b0, rd_data[6]}, 8'h00);
    @(negedge clk); lvl_req[2] = 1'b1;
    @(negedge clk);
    write_byte(8'h10);
    @(negedge clk); @(negedge clk);
    chk("R5 no relatch on level", {7'b0, rd_data[6]}, 8'h00);
    lvl_req[2] = 1'b0;

    // R6 level-sensed
    @(negedge clk); lvl_req[1] = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R6 pend 6.5", {5'b0, rd_data[6:4]}, 8'h02);
    lvl_req[1] = 1'b0; lvl_req[0] = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R6 pend 5.5", {5'b0, rd_data[6:4]}, 8'h01);
    lvl_req[0] = 1'b0;

    // R8 enable / disable
    pulse_cmd(1'b1, 1'b1); @(negedge clk);
    chk("R8 disable wins", {7'b0, rd_data[3]}, 8'h00);
    pulse_cmd(1'b1, 1'b0); @(negedge clk);
    chk("R8 enable", {7'b0, rd_data[3]}, 8'h01);
    pulse_cmd(1'b0, 1'b1); @(negedge clk);
    chk("R8 disable", {7'b0, rd_data[3]}, 8'h00);

    // R9 non-maskable with everything masked and disabled
    write_byte(8'b0000_1111);
    @(negedge clk); nmi_req = 1'b1;
    @(negedge clk);
    chk("R9 nmi valid", {6'b0, irq_valid, 1'b0}, 8'h02);
    chk("R9 nmi id", {6'b0, irq_id}, 8'h00);
    nmi_req = 1'b0;

    // R11 accept clears enable; ack of 7.5 clears capture
    write_byte(8'b0000_1000);
    pulse_cmd(1'b1, 1'b0);
    @(negedge clk); lvl_req[0] = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R11 pre id", {6'b0, irq_id}, 8'h03);
    ack = 1'b1;
    @(negedge clk); ack = 1'b0;
    chk("R11 valid drops", {7'b0, irq_valid}, 8'h00);
    @(negedge clk);
    chk("R11 enable cleared", {7'b0, rd_data[3]}, 8'h00);
    lvl_req[0] = 1'b0;
    pulse_cmd(1'b1, 1'b0);
    @(negedge clk); lvl_req[2] = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R5 id 7.5", {6'b0, irq_id}, 8'h01);
    ack = 1'b1;
    @(negedge clk); ack = 1'b0;
    @(negedge clk);
    chk("R5 ack clears capture", {7'b0, rd_data[6]}, 8'h00);
    lvl_req[2] = 1'b0;

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog got=hung exp=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule